// File: doc/BRIEF.md
# Metering Serial Port Slave

This block is the device side of a four-wire serial port on a measurement chip. It runs in the system clock domain and samples the pins synchronously. The pins are a select line (active low), a sync line, a serial clock and a data line. The data line is split into an input, an output and an output enable. The sync line does two jobs. While select is high, a low pulse on sync copies the live measurement values into eight 32-bit transmission latches. While select is low, sync chooses the direction: high means read and the block drives data, low means write and data is an input.

In read mode the eight latched records go out in a fixed order, one bit per serial clock rising edge. Each record is sent least significant byte first. Every record has a parity nibble in its top four bits. Six records carry measurement data, and the last two read back the configuration array. In write mode, 8-bit command bytes set or clear single bits of a 64-bit configuration array. The byte 0xFF is a precharge command: when it arrives right after the second record has been read, it moves the read pointer past the next two records.

Top module: `meter_serial_port`

## Requirements
- R1: `port_doe` is 1 only while select is low and sync is high (read mode). It is 0 after reset, while select is high, and in write mode.
- R2: A sync low pulse of at least LATCH_MIN (default 4) system clocks while select is high updates all eight latches when sync rises. A shorter pulse leaves them unchanged.
- R3: Record k (k = 0..5) holds `meas_words[k*28 +: 28]` in bits 27:0. Record 6 holds `cfg_bits[27:0]` and record 7 holds `cfg_bits[55:28]`. Bits 31:28 are parity, chosen so that the XOR of all eight nibbles of the word is 0xF. After reset every record reads 0xF0000000.
- R4: Read mode sends one bit per serial clock rising edge. Byte 0 (bits 7:0) goes first and byte 3 last. Within a byte the MSB goes first when `cfg_bits[MSBF_BIT]` (default bit 50) is 0, and the LSB goes first when it is 1.
- R5: A falling edge of select resets the read position to bit 0 of record 0. A second pass with no latch pulse in between returns identical data.
- R6: After all eight records have been sent, further read clocks give all ones.
- R7: In write mode, bits are taken MSB first on serial clock rising edges. In each 8-bit byte, bit 7 is the value, bits 6:1 are the configuration bit address, and bit 0 is ignored. Several bytes may be sent in one window, and each takes effect when its eighth bit arrives.
- R8: Byte 0xFF writes nothing. If it arrives while the read position is at bit 0 of record 2, the position jumps to bit 0 of record 4. At any other position it is ignored.
- R9: While select is low, changes on `meas_words` do not alter the data read out.
- R10: After reset, `cfg_bits` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel_n | input | 1 | Port select, active low |
| port_sync | input | 1 | Sync: latch strobe while deselected, direction while selected |
| port_clk | input | 1 | Serial bit clock |
| port_din | input | 1 | Serial data in (write mode) |
| port_dout | output | 1 | Serial data out (read mode) |
| port_doe | output | 1 | Output enable for the data pin |
| meas_words | input | 168 | Six 28-bit live measurement values, record 0 in the low bits |
| cfg_bits | output | 64 | Configuration and mode bit array |

## Verification
The bench targets the latch strobe boundary. A pulse three cycles long must be ignored and a pulse four cycles long must be taken, so a comparator that is off by one either refreshes on glitches or drops legal strobes. It compares the byte order and the bit order within each byte under both settings of the bit-order control; a swapped byte order or a control bit that is ignored garbles every record. It sets and clears every configuration address in turn and confirms that 0xFF never writes address 63. It sends precharge both at the legal point and at the start of a pass; a decoder that jumps at any position, or never jumps, reads the wrong record. Finally it reads past the eighth record, where a pointer that wraps would show record 0 again instead of all ones.

// File: rtl/msp_pkg.sv
// Package: shared constants and the parity sealing helpers of the
// metering serial port. Assumes 32-bit records with a 4-bit parity nibble.
package msp_pkg;
    localparam int REC_W    = 32;
    localparam int DATA_W   = 28;
    localparam int NIB_W    = 4;
    localparam int PRE_FROM = 2;   // record index at which precharge is honoured
    localparam int PRE_TO   = 4;   // record index precharge jumps to

    // Build a record: parity nibble makes the XOR of all nibbles equal 0xF.
    function automatic logic [REC_W-1:0] msp_seal(input logic [DATA_W-1:0] d);
        logic [NIB_W-1:0] p;
        p = 4'hF;
        for (int i = 0; i < DATA_W/NIB_W; i++) p ^= d[i*NIB_W +: NIB_W];
        return {p, d};
    endfunction

    // XOR fold of all nibbles of a record, used by parity checks.
    function automatic logic [NIB_W-1:0] msp_fold(input logic [REC_W-1:0] w);
        logic [NIB_W-1:0] x;
        x = '0;
        for (int i = 0; i < REC_W/NIB_W; i++) x ^= w[i*NIB_W +: NIB_W];
        return x;
    endfunction
endpackage

// File: rtl/msp_sync.sv
// Module: multi-stage synchronizer for the asynchronous port pins.
// Assumes pins idle high, so every stage resets to one.
module msp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift pin values one stage deeper each clock.
        always_ff @(posedge clk) begin
            if (!rst_n)      stg[s] <= '1;
            else if (s == 0) stg[s] <= d;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/msp_latch_bank.sv
// Module: transmission latches. Captures sealed records when a sync low
// pulse of at least LATCH_MIN cycles ends while the port is deselected.
// Assumes synchronized inputs; records NREC-2 and NREC-1 read back config.
module msp_latch_bank import msp_pkg::*; #(
    parameter int NREC      = 8,
    parameter int LATCH_MIN = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel_n,
    input  logic                           sync,
    input  logic                           sync_rise,
    input  logic [(NREC-2)*DATA_W-1:0]     meas_words,
    input  logic [2*DATA_W-1:0]            cfg_lo,
    output logic [NREC*REC_W-1:0]          rec_flat
);
    localparam int LC_W = $clog2(LATCH_MIN + 1);

    logic [LC_W-1:0]  low_cnt;
    logic             capture;
    logic [REC_W-1:0] words [NREC];

    // Count cycles of sync low while deselected, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_cnt <= '0;
        else if (sel_n && !sync) begin
            if (low_cnt != LC_W'(LATCH_MIN)) low_cnt <= low_cnt + 1'b1;
        end
        else                       low_cnt <= '0;
    end

    assign capture = sel_n && sync_rise && (low_cnt == LC_W'(LATCH_MIN));

    for (genvar r = 0; r < NREC; r++) begin : g_rec
        logic [DATA_W-1:0] src;
        if (r < NREC-2) begin : g_meas
            assign src = meas_words[r*DATA_W +: DATA_W];
        end else begin : g_cfg
            assign src = cfg_lo[(r-(NREC-2))*DATA_W +: DATA_W];
        end

        // Load the sealed record on a qualified latch strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)       words[r] <= msp_seal('0);
            else if (capture) words[r] <= msp_seal(src);
        end

        assign rec_flat[r*REC_W +: REC_W] = words[r];

        // R3
        parity_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            msp_fold(words[r]) == 4'hF);
    end

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !$past(sel_n)) |-> $stable(rec_flat));
endmodule

// File: rtl/msp_shifter.sv
// Module: read-side shifter. Walks records and bits on serial clock rising
// edges in read mode, applies the byte and bit order, and honours precharge.
// Assumes synchronized select/sync and single-cycle edge pulses.
module msp_shifter import msp_pkg::*; #(
    parameter int NREC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_n,
    input  logic                   sync,
    input  logic                   sel_fell,
    input  logic                   clk_rise,
    input  logic                   precharge,
    input  logic                   msbf,
    input  logic [NREC*REC_W-1:0]  rec_flat,
    output logic                   dout
);
    localparam int RP_W = $clog2(NREC + 1);
    localparam int BP_W = $clog2(REC_W);

    logic [RP_W-1:0]  rec_ptr;
    logic [BP_W-1:0]  bit_ptr;
    logic [REC_W-1:0] word;
    logic [BP_W-1:0]  pos;
    logic             done;
    logic             pre_ok;

    assign done   = (rec_ptr == RP_W'(NREC));
    assign pre_ok = precharge && (rec_ptr == RP_W'(PRE_FROM)) && (bit_ptr == '0);

    // Advance, reset or jump the read position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_ptr <= '0;
            bit_ptr <= '0;
        end else if (sel_fell) begin
            rec_ptr <= '0;
            bit_ptr <= '0;
        end else if (pre_ok) begin
            rec_ptr <= RP_W'(PRE_TO);
        end else if (!sel_n && sync && clk_rise && !done) begin
            bit_ptr <= bit_ptr + 1'b1;
            if (bit_ptr == BP_W'(REC_W-1)) rec_ptr <= rec_ptr + 1'b1;
        end
    end

    // Select the record under the read pointer.
    always_comb begin
        word = '1;
        for (int r = 0; r < NREC; r++)
            if (rec_ptr == RP_W'(r)) word = rec_flat[r*REC_W +: REC_W];
    end

    // Byte order is fixed LS byte first; bit order within a byte follows msbf.
    assign pos  = {bit_ptr[BP_W-1:3], msbf ? bit_ptr[2:0] : ~bit_ptr[2:0]};
    assign dout = done ? 1'b1 : word[pos];

    // R5
    ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fell |=> (rec_ptr == '0 && bit_ptr == '0));
    // R6
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ptr <= RP_W'(NREC));
    // R8
    pre_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (precharge && !sel_fell && rec_ptr == RP_W'(PRE_FROM) && bit_ptr == '0)
        |=> rec_ptr == RP_W'(PRE_TO));
endmodule

// File: rtl/msp_cmd.sv
// Module: write-side command decoder. Assembles command bytes MSB first in
// write mode and sets or clears one configuration bit, or flags precharge.
// Assumes synchronized inputs and single-cycle edge pulses.
module msp_cmd #(
    parameter int CFG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sync,
    input  logic             sel_fell,
    input  logic             sync_fell,
    input  logic             clk_rise,
    input  logic             din,
    output logic             precharge,
    output logic [CFG_W-1:0] cfg_bits
);
    localparam int ADDR_W  = $clog2(CFG_W);
    localparam int CMD_LEN = ADDR_W + 2;
    localparam int CNT_W   = $clog2(CMD_LEN);

    logic [ADDR_W:0]  shreg;
    logic [CNT_W-1:0] cnt;
    logic             wr_take;
    logic             last_bit;
    logic             is_pre;

    assign wr_take  = !sel_n && !sync && clk_rise;
    assign last_bit = wr_take && (cnt == CNT_W'(CMD_LEN-1));
    assign is_pre   = (&shreg) && din;

    // Shift command bits and count them within the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (sel_fell || (!sel_n && sync_fell)) begin
            cnt   <= '0;
        end else if (wr_take) begin
            shreg <= {shreg[ADDR_W-1:0], din};
            cnt   <= last_bit ? '0 : cnt + 1'b1;
        end
    end

    // Apply a completed byte: a bit write, or a precharge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_bits  <= '0;
            precharge <= 1'b0;
        end else begin
            precharge <= last_bit && is_pre;
            if (last_bit && !is_pre) cfg_bits[shreg[ADDR_W-1:0]] <= shreg[ADDR_W];
        end
    end

    // R7
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !is_pre) |=> cfg_bits[$past(shreg[ADDR_W-1:0])] == $past(shreg[ADDR_W]));
endmodule

// File: rtl/meter_serial_port.sv
// Module: top of the metering serial port slave. Synchronizes the pins,
// derives edges, and connects latch bank, shifter and command decoder.
// Assumes pins idle high and a system clock well above the serial clock.
module meter_serial_port import msp_pkg::*; #(
    parameter int NREC        = 8,
    parameter int CFG_W       = 64,
    parameter int SYNC_STAGES = 2,
    parameter int LATCH_MIN   = 4,
    parameter int MSBF_BIT    = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       port_sel_n,
    input  logic                       port_sync,
    input  logic                       port_clk,
    input  logic                       port_din,
    output logic                       port_dout,
    output logic                       port_doe,
    input  logic [(NREC-2)*DATA_W-1:0] meas_words,
    output logic [CFG_W-1:0]           cfg_bits
);
    logic [3:0] pins_q;
    logic sel_q, sync_q, clk_q, din_q;
    logic sel_d, sync_d, clk_d;
    logic sel_fell, sync_fell, sync_rise, clk_rise;
    logic precharge;
    logic [NREC*REC_W-1:0] rec_flat;

    msp_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({port_sel_n, port_sync, port_clk, port_din}),
        .q(pins_q)
    );
    assign {sel_q, sync_q, clk_q, din_q} = pins_q;

    // Hold last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) {sel_d, sync_d, clk_d} <= 3'b111;
        else        {sel_d, sync_d, clk_d} <= {sel_q, sync_q, clk_q};
    end

    assign sel_fell  = sel_d && !sel_q;
    assign sync_fell = sync_d && !sync_q;
    assign sync_rise = !sync_d && sync_q;
    assign clk_rise  = !clk_d && clk_q;

    msp_latch_bank #(.NREC(NREC), .LATCH_MIN(LATCH_MIN)) u_latch (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_q), .sync(sync_q),
        .sync_rise(sync_rise), .meas_words(meas_words),
        .cfg_lo(cfg_bits[2*DATA_W-1:0]), .rec_flat(rec_flat)
    );

    msp_shifter #(.NREC(NREC)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_q), .sync(sync_q),
        .sel_fell(sel_fell), .clk_rise(clk_rise), .precharge(precharge),
        .msbf(cfg_bits[MSBF_BIT]), .rec_flat(rec_flat), .dout(port_dout)
    );

    msp_cmd #(.CFG_W(CFG_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_q), .sync(sync_q),
        .sel_fell(sel_fell), .sync_fell(sync_fell), .clk_rise(clk_rise),
        .din(din_q), .precharge(precharge), .cfg_bits(cfg_bits)
    );

    assign port_doe = !sel_q && sync_q;
endmodule

// File: tb/sim_meter_serial_port.sv
module sim_meter_serial_port;
    localparam int NREC = 8, DW = 28, LMIN = 4, MSBF = 50, H = 8;

    logic clk = 0, rst_n = 0;
    logic sel_n = 1, syn = 1, sck = 1, din = 1;
    logic dout, doe;
    logic [(NREC-2)*DW-1:0] meas = '0;
    logic [63:0] cfg;

    int checks = 0, errors = 0;
    logic [63:0] exp_cfg = '0;
    logic [31:0] lat [NREC];
    bit msbf_on = 0;

    meter_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .port_sel_n(sel_n), .port_sync(syn),
        .port_clk(sck), .port_din(din), .port_dout(dout), .port_doe(doe),
        .meas_words(meas), .cfg_bits(cfg)
    );

    always #2 clk = ~clk;

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seal(input logic [27:0] d);
        logic [3:0] p = 4'hF;
        for (int i = 0; i < 7; i++) p ^= d[i*4 +: 4];
        return {p, d};
    endfunction

    task automatic do_latch(input int w);
        syn = 0; wcyc(w); syn = 1; wcyc(6);
        if (w >= LMIN) begin
            for (int k = 0; k < NREC-2; k++) lat[k] = seal(meas[k*DW +: DW]);
            lat[6] = seal(exp_cfg[27:0]);
            lat[7] = seal(exp_cfg[55:28]);
        end
    endtask

    task automatic open_read;  syn = 1; wcyc(4); sel_n = 0; wcyc(6); endtask
    task automatic open_write; sel_n = 0; wcyc(4); syn = 0; wcyc(6); endtask
    task automatic close_port; syn = 1; wcyc(4); sel_n = 1; wcyc(6); endtask

    task automatic read_word(output logic [31:0] w);
        w = '0;
        for (int i = 0; i < 32; i++) begin
            sck = 0; wcyc(H);
            w[(i/8)*8 + (msbf_on ? i%8 : 7 - i%8)] = dout;
            sck = 1; wcyc(H);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sck = 0; din = b[i]; wcyc(H);
            sck = 1; wcyc(H);
        end
        din = 1;
    endtask

    task automatic set_cfg(input int a, input bit v);
        write_byte({v, 6'(a), 1'b0});
        exp_cfg[a] = v;
    endtask

    task automatic read_all(input string tag);
        logic [31:0] w;
        for (int k = 0; k < NREC; k++) begin
            read_word(w);
            chk(w === lat[k], tag, 64'(w), 64'(lat[k]));
        end
    endtask

    task automatic fill_meas(input int pat);
        for (int k = 0; k < NREC-2; k++)
            meas[k*DW +: DW] = 28'((32'h9E3779B1 * (k + 1 + pat*7)) ^ (pat << 5));
    endtask

    initial begin : main
        logic [31:0] w;
        wcyc(5); rst_n = 1; wcyc(5);
        // R10, R1: reset state
        chk(cfg === '0, "R10 cfg reset", cfg, 0);
        chk(doe === 0, "R1 doe idle", 64'(doe), 0);
        for (int k = 0; k < NREC; k++) lat[k] = 32'hF000_0000;
        open_read;
        chk(doe === 1, "R1 doe read mode", 64'(doe), 1);
        read_all("R3 reset records");
        read_word(w);
        chk(w === 32'hFFFF_FFFF, "R6 ones after last record", 64'(w), 64'hFFFF_FFFF);
        close_port;
        chk(doe === 0, "R1 doe released", 64'(doe), 0);

        // R3, R5, R9: several patterns, two passes, live inputs change mid-pass
        for (int pat = 0; pat < 4; pat++) begin
            fill_meas(pat); do_latch(8);
            open_read;
            read_word(w);
            chk(w === lat[0], "R3 record 0", 64'(w), 64'(lat[0]));
            fill_meas(pat + 10);
            for (int k = 1; k < NREC; k++) begin
                read_word(w);
                chk(w === lat[k], "R9 record with live change", 64'(w), 64'(lat[k]));
            end
            close_port;
            open_read; read_all("R5 repeat pass"); close_port;
        end

        // R2: strobe width boundary
        fill_meas(20); do_latch(LMIN - 1);
        open_read; read_all("R2 short pulse ignored"); close_port;
        do_latch(LMIN);
        open_read; read_all("R2 minimum pulse taken"); close_port;

        // R7, R1: every address set and cleared in one write window
        open_write;
        chk(doe === 0, "R1 doe write mode", 64'(doe), 0);
        for (int a = 0; a < 64; a++) begin
            write_byte({1'b1, 6'(a), (a == 63) ? 1'b0 : a[0]});
            chk(cfg === (64'd1 << a), "R7 set bit", cfg, 64'd1 << a);
            write_byte({1'b0, 6'(a), ~a[0]});
            chk(cfg === '0, "R7 clear bit", cfg, 0);
        end
        // R8: 0xFF is not a write to address 63
        write_byte(8'hFF);
        chk(cfg === '0, "R8 precharge writes nothing", cfg, 0);
        set_cfg(3, 1); set_cfg(30, 1); set_cfg(55, 1); set_cfg(60, 1);
        chk(cfg === exp_cfg, "R7 multi-byte window", cfg, exp_cfg);
        close_port;

        // R3: config readback records
        fill_meas(30); do_latch(8);
        open_read; read_all("R3 config readback"); close_port;

        // R8: precharge after second record jumps to record 4
        open_read;
        read_word(w); read_word(w);
        syn = 0; wcyc(6); write_byte(8'hFF); syn = 1; wcyc(6);
        read_word(w);
        chk(w === lat[4], "R8 precharge jump", 64'(w), 64'(lat[4]));
        read_word(w);
        chk(w === lat[5], "R8 continue after jump", 64'(w), 64'(lat[5]));
        close_port;
        // R8: precharge at start of pass is ignored
        open_read;
        syn = 0; wcyc(6); write_byte(8'hFF); syn = 1; wcyc(6);
        read_word(w);
        chk(w === lat[0], "R8 precharge ignored", 64'(w), 64'(lat[0]));
        close_port;

        // R4: LSB-first bit order
        open_write; set_cfg(MSBF, 1); close_port;
        msbf_on = 1;
        fill_meas(40); do_latch(8);
        open_read; read_all("R4 lsb-first order"); close_port;
        open_write; set_cfg(MSBF, 0); close_port;
        msbf_on = 0;
        open_read; read_all("R4 msb-first order"); close_port;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule